// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block is the interrupt front end of one processor. It keeps a 32-bit local pending word that holds fifteen software interrupt bits in its upper half, a copy of the processor's own timer request and a latched copy of a level-15 request that is broadcast to every processor. It merges these with two level vectors that a system router computes for this processor. The result drives fifteen registered interrupt level lines, numbered 1 to 15. No line exists for level 0.

The router supplies two vectors. The seen vector has a bit set for each level that has a pending source, whether that source is enabled or not, and it is used only for readback. The live vector holds only the enabled sources and feeds the output lines. A master disable input blocks the timer, level-15 and live contributions. Software interrupts are never masked. Software accesses the block through a word-addressed 32-bit port: offset 0 reads the pending view, offset 1 clears bits, offset 2 sets bits, and offset 3 is unmapped.

Top module: `cpu_irl_combiner`

## Requirements
- R1: A read at offset 0 returns this view: bits 31..17 are the soft bits, bit 16 is 0, bit 15 is the level-15 latch OR seen level 15, bit 14 is the timer copy OR seen level 14, bits 13..1 equal seen levels 13..1, and bit 0 is 0. The seen bits appear even while the master disable input is high.
- R2: A write to offset 2 ORs wdata bits 31..17 into the soft bits. Every other wdata bit has no effect.
- R3: A write to offset 1 clears the soft bits and bit 15 where wdata has a 1. Every other wdata bit has no effect.
- R4: Bit 14 of the pending word equals the timer input sampled at the previous clock edge.
- R5: A rising edge on the level-15 input sets bit 15 one cycle later, and a falling edge clears it. A clear write can drop bit 15 while the input stays high. When a rising edge and a clear write fall in the same cycle, the bit is set.
- R6: Soft bit k (17..31) drives level k-16 whatever the state of master disable.
- R7: While master disable is high, the timer bit, bit 15 and the live vector do not reach the outputs. While it is low, they drive levels 14, 15 and their own levels.
- R8: Each output line is a register that equals the OR of its contributors one clock after they are present. The seen vector never drives the outputs.
- R9: Reads at offsets 1, 2 and 3 return 0, and a write to offset 3 changes nothing.
- R10: Synchronous reset clears the pending word and all output lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_en_i | input | 1 | access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | word offset |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data, combinational, 0 when no read is active |
| hard_seen_i | input | 15 | levels 1..15 with any pending source, shown in readback only |
| hard_live_i | input | 15 | levels 1..15 with an enabled pending source |
| mdis_i | input | 1 | master disable |
| timer_i | input | 1 | this processor's timer request level |
| l15_i | input | 1 | broadcast level-15 request |
| irl_o | output | 15 | interrupt level lines 1..15 |

## Verification
A corrupted soft bit shows up in two ways: the offset-0 readback is wrong on the very next read, and the line for the matching level is wrong two edges after the write. A bad timer copy or level-15 latch can be seen in readback one edge after the input changes, and on the outputs one edge after that. A wrong gating decision in the merge stage shows on the lines at the next edge. The bench sweeps every write-data bit for both set and clear, every seen level and every live level with master disable high and low, so a misplaced mask or shift changes a specific readback bit or a specific line.

// File: rtl/lvlcomb_pkg.sv
package lvlcomb_pkg;
    localparam int unsigned NLVL    = 15;
    localparam int unsigned DW      = 32;
    localparam int unsigned AW      = 2;
    localparam int unsigned SOFT_LO = DW - NLVL;      // lowest soft bit
    localparam int unsigned TBIT    = NLVL - 1;       // timer copy
    localparam int unsigned HBIT    = NLVL;           // level-15 latch
    localparam int unsigned PADW    = DW - NLVL - 1;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [AW-1:0] {
        OFS_PEND = 2'd0,
        OFS_CLR  = 2'd1,
        OFS_SET  = 2'd2,
        OFS_NONE = 2'd3
    } ofs_e;

    typedef struct packed {
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        word_t         wdata;
    } bus_req_t;

    function automatic word_t soft_mask();
        return {{NLVL{1'b1}}, {SOFT_LO{1'b0}}};
    endfunction

    function automatic word_t clr_mask();
        word_t m;
        m       = soft_mask();
        m[HBIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/lvlcomb_pend.sv
module lvlcomb_pend
    import lvlcomb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     timer_i,
    input  logic     l15_i,
    output word_t    pend_o
);
    word_t pend_q, pend_n;
    logic  l15_prev;
    logic  wr_clr, wr_set, wr_none;

    assign wr_clr  = req.en && req.we && (ofs_e'(req.addr) == OFS_CLR);
    assign wr_set  = req.en && req.we && (ofs_e'(req.addr) == OFS_SET);
    assign wr_none = req.en && req.we && (ofs_e'(req.addr) == OFS_NONE);

    always_comb begin
        pend_n = pend_q;
        if (wr_clr) pend_n = pend_n & ~(req.wdata & clr_mask());
        if (wr_set) pend_n = pend_n | (req.wdata & soft_mask());
        pend_n[TBIT] = timer_i;
        if (l15_i && !l15_prev)      pend_n[HBIT] = 1'b1;
        else if (!l15_i && l15_prev) pend_n[HBIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            l15_prev <= 1'b0;
        end else begin
            pend_q   <= pend_n;
            l15_prev <= l15_i;
        end
    end

    assign pend_o = pend_q;

    p_set_soft_r2: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((pend_q & $past(req.wdata & soft_mask())) == $past(req.wdata & soft_mask())));
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_none && $stable(l15_i)) |=> ($past(pend_q[DW-1:SOFT_LO]) == pend_q[DW-1:SOFT_LO]));
    p_timer_copy_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_q[TBIT] == $past(timer_i)));
endmodule

// File: rtl/lvlcomb_merge.sv
module lvlcomb_merge
    import lvlcomb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NLVL:1]   soft_i,
    input  logic            tmr_i,
    input  logic            l15_i,
    input  logic [NLVL:1]   live_i,
    input  logic            mdis_i,
    output logic [NLVL:1]   irl_o
);
    logic [NLVL:1] gated, nxt, irl_q;

    always_comb begin
        gated       = live_i;
        gated[TBIT] = gated[TBIT] | tmr_i;
        gated[HBIT] = gated[HBIT] | l15_i;
        if (mdis_i) gated = '0;
        nxt = gated | soft_i;
    end

    for (genvar l = 1; l <= NLVL; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                irl_q[l] <= 1'b0;
            else if (nxt[l] != irl_q[l])
                irl_q[l] <= nxt[l];
        end
    end

    assign irl_o = irl_q;

    p_soft_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        (soft_i != '0) |=> ((irl_o & $past(soft_i)) == $past(soft_i)));
    p_mdis_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (mdis_i && soft_i == '0) |=> (irl_o == '0));
endmodule

// File: rtl/cpu_irl_combiner.sv
module cpu_irl_combiner
    import lvlcomb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic [AW-1:0]       bus_addr_i,
    input  logic [DW-1:0]       bus_wdata_i,
    output logic [DW-1:0]       bus_rdata_o,
    input  logic [NLVL:1]       hard_seen_i,
    input  logic [NLVL:1]       hard_live_i,
    input  logic                mdis_i,
    input  logic                timer_i,
    input  logic                l15_i,
    output logic [NLVL:1]       irl_o
);
    bus_req_t req;
    word_t    pend, view;
    logic     rd_pend;

    assign req = '{en: bus_en_i, we: bus_we_i, addr: bus_addr_i, wdata: bus_wdata_i};

    lvlcomb_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .timer_i (timer_i),
        .l15_i   (l15_i),
        .pend_o  (pend)
    );

    lvlcomb_merge u_merge (
        .clk    (clk),
        .rst    (rst),
        .soft_i (pend[DW-1:SOFT_LO]),
        .tmr_i  (pend[TBIT]),
        .l15_i  (pend[HBIT]),
        .live_i (hard_live_i),
        .mdis_i (mdis_i),
        .irl_o  (irl_o)
    );

    assign view        = pend | {{PADW{1'b0}}, hard_seen_i, 1'b0};
    assign rd_pend     = bus_en_i && !bus_we_i && (ofs_e'(bus_addr_i) == OFS_PEND);
    assign bus_rdata_o = rd_pend ? view : '0;

    p_unmapped_rd_r9: assert property (@(posedge clk)
        (bus_en_i && !bus_we_i && bus_addr_i != '0) |-> (bus_rdata_o == '0));
    p_reset_clear_r10: assert property (@(posedge clk)
        $past(rst) |-> (irl_o == '0));
endmodule

// File: tb/cpu_irl_combiner_tb.sv
module cpu_irl_combiner_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:1] seen = '0, live = '0, irl;
    logic        mdis = 1'b0, tmr = 1'b0, l15 = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [15:1] soft_m = '0;
    logic        tmr_m = 1'b0, l15_m = 1'b0;

    always #10 clk = ~clk;

    cpu_irl_combiner u_dut (
        .clk(clk), .rst(rst), .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .hard_seen_i(seen),
        .hard_live_i(live), .mdis_i(mdis), .timer_i(tmr), .l15_i(l15), .irl_o(irl)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_view();
        return {soft_m, 1'b0, 16'h0} | {16'h0, l15_m, tmr_m, 14'h0} | {16'h0, seen, 1'b0};
    endfunction

    function automatic logic [31:0] exp_irl();
        logic [15:0] e;
        e = {soft_m, 1'b0};
        if (!mdis) e = e | {live, 1'b0} | {l15_m, tmr_m, 14'h0};
        return {16'h0, e};
    endfunction

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); en = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); en = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        bus_rd(2'd0, v);
        check({tag, " view"}, v, exp_view());
        check({tag, " irl"}, {16'h0, irl, 1'b0}, exp_irl());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R10 reset");

        // R2/R6 and R3: sweep every write-data bit
        for (int b = 0; b < 32; b++) begin
            bus_wr(2'd2, 32'h1 << b);
            if (b >= 17) soft_m[b-16] = 1'b1;
            settle();
            check_state("R2 R6 set sweep");
            bus_wr(2'd1, 32'h1 << b);
            if (b >= 17) soft_m[b-16] = 1'b0;
            settle();
            check_state("R3 clear sweep");
        end
        bus_wr(2'd2, 32'hFFFF_FFFF);
        soft_m = '1;
        bus_wr(2'd1, 32'h0001_7FFF);
        settle();
        check_state("R3 non-mask clear ignored");
        bus_wr(2'd1, 32'hFFFF_FFFF);
        soft_m = '0;
        settle();

        // R4: timer copy lands one edge later; R7 gating
        @(negedge clk); tmr = 1'b1;
        bus_rd(2'd0, v);
        check("R4 timer copy after one edge", {31'h0, v[14]}, 32'h1);
        tmr_m = 1'b1;
        settle();
        check_state("R4 R7 timer on");
        mdis = 1'b1; settle();
        check_state("R7 timer masked by mdis");
        mdis = 1'b0;
        tmr = 1'b0; tmr_m = 1'b0; settle();

        // R5: level-15 latch
        @(negedge clk); l15 = 1'b1;
        bus_rd(2'd0, v);
        check("R5 l15 set after one edge", {31'h0, v[15]}, 32'h1);
        l15_m = 1'b1; settle();
        check_state("R5 l15 on");
        bus_wr(2'd1, 32'h0000_8000);
        l15_m = 1'b0; settle();
        check_state("R5 clear write while input high");
        l15 = 1'b0; settle();
        @(negedge clk); l15 = 1'b1; en = 1'b1; we = 1'b1; addr = 2'd1; wdata = 32'h0000_8000;
        @(negedge clk); en = 1'b0; we = 1'b0;
        l15_m = 1'b1; settle();
        check_state("R5 rise wins over clear");
        l15 = 1'b0; l15_m = 1'b0; settle();
        check_state("R5 fall clears");

        // R1: seen vector readback, any mdis
        for (int l = 1; l <= 15; l++) begin
            for (int m = 0; m < 2; m++) begin
                seen = 15'h1 << (l - 1); mdis = m[0];
                settle();
                check_state("R1 R8 seen level");
            end
        end
        seen = '0; mdis = 1'b0;

        // R8/R7: live levels, one-edge output latency
        for (int l = 1; l <= 15; l++) begin
            @(negedge clk); live = 15'h1 << (l - 1);
            @(negedge clk);
            check("R8 live after one edge", {16'h0, irl, 1'b0}, exp_irl());
            mdis = 1'b1;
            @(negedge clk);
            check("R7 live masked", {16'h0, irl, 1'b0}, exp_irl());
            mdis = 1'b0;
        end
        live = 15'h7FFF; mdis = 1'b1;
        bus_wr(2'd2, 32'h8000_0000); soft_m[15] = 1'b1;
        settle();
        check_state("R6 soft unmasked under mdis");
        live = '0; mdis = 1'b0;

        // R9: unmapped and write-only offsets
        for (int a = 1; a < 4; a++) begin
            bus_rd(2'(a), v);
            check("R9 non-pend read zero", v, 32'h0);
        end
        bus_wr(2'd3, 32'hFFFF_FFFF);
        settle();
        check_state("R9 unmapped write ignored");

        // R10: reset mid-run
        bus_wr(2'd2, 32'hAAAA_0000);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        soft_m = '0; tmr_m = 1'b0; l15_m = 1'b0;
        check("R10 irl after reset", {16'h0, irl, 1'b0}, 32'h0);
        rst = 1'b0;
        check_state("R10 view after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule